// File: doc/BRIEF.md
# Frequency Sweep Command Generator

This block steps a serially controlled function generator through a list of output frequencies. A start pulse latches three unsigned values: the first frequency, an exclusive upper limit and an increment, all counted in centihertz (0.01 Hz). For every point below the limit, the block converts the current value to decimal ASCII. It sends that value to the generator inside a short text command through its own asynchronous serial transmitter, then moves to the next point.

Two pacing modes are available. With the handshake disabled, each command follows the previous one as soon as the last stop bit has left the line. With the handshake enabled, the block pulses a point-sent strobe after each command and holds the line idle until a point-complete pulse arrives. This gives a capture engine time to measure the response at that frequency. A one-cycle done pulse closes the sweep. With default settings the block sweeps from 10 kHz in 10 Hz steps, and the last command it sends is 89,999,000 centihertz.

Top module: `sweep_cmd_gen`

## Requirements
- R1: Every command is the byte sequence 0x3A (':'), 0x73 ('s'), 0x31 ('1'), 0x66 ('f'), then the frequency digits, then 0x0D and 0x0A, with no other bytes between or around them.
- R2: The frequency digits are the point's value in centihertz, written in decimal ASCII (0x30 to 0x39), most significant digit first, without leading zeros. A value of zero is sent as the single digit '0', and values up to 999,999,999 (nine digits) are supported.
- R3: Each byte goes out as one low start bit, eight data bits LSB first and one high stop bit. Each bit lasts CLK_HZ/BAUD clock cycles, and the line rests high whenever nothing is being sent.
- R4: The sweep sends the points start, start+step, start+2*step and so on, for as long as the point is strictly below the stop value. When start is not below stop, no byte is sent.
- R5: With the handshake disabled, the start bit of the next byte (inside a command or of the next command) begins within two clock cycles after the previous stop bit ends.
- R6: With the handshake enabled, after each command's final stop bit the block keeps the line high and busy asserted, and sends nothing, until point_done is pulsed.
- R7: done is high for exactly one cycle at the end of a sweep, after the last command's final stop bit has ended (or right after start when no points exist). busy is high from the cycle after an accepted start with points until done, and busy is low while done is high.
- R8: A start pulse that arrives while busy is high is ignored: the running sweep continues with its original values.
- R9: A synchronous reset, even in the middle of a sweep, returns the block to idle with tx high, busy low and done low.
- R10: point_sent is high for exactly one cycle after each command's final stop bit has ended, in both pacing modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a sweep (ignored while busy) |
| start_freq | input | 32 | First point, centihertz |
| stop_freq | input | 32 | Exclusive upper limit, centihertz |
| step_freq | input | 32 | Increment between points, centihertz |
| handshake_en | input | 1 | Wait for point_done after each command |
| point_done | input | 1 | Capture for the current point has finished |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| point_sent | output | 1 | One-cycle pulse after each command |
| tx | output | 1 | Serial data line to the generator |

## Verification
The hardest condition to reach from the ports is a late start request or a reset that lands inside a command that is already on the wire. From outside, that state shows only as a serial line in mid-byte. The bench decodes the line with its own receiver, counts received commands, and injects a start pulse with different values once the first command has been decoded. It also asserts reset a few hundred cycles into a sweep, while the receiver is muted. Handshake holds and the spacing between back-to-back bytes are measured against the same decoded stream.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    localparam logic [7:0] CH_COLON = 8'h3A;
    localparam logic [7:0] CH_S     = 8'h73;
    localparam logic [7:0] CH_ONE   = 8'h31;
    localparam logic [7:0] CH_F     = 8'h66;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;
    localparam logic [7:0] CH_ZERO  = 8'h30;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_EMIT,
        SQ_DRAIN,
        SQ_HOLD
    } seq_state_t;

    typedef enum logic [2:0] {
        FLD_HEAD,
        FLD_SIZE,
        FLD_DIGIT,
        FLD_CR,
        FLD_LF
    } fld_t;

    typedef enum logic [1:0] {
        LN_IDLE,
        LN_START,
        LN_DATA,
        LN_STOP
    } line_state_t;

    // Power of ten as a 64-bit value, for exponents up to 18.
    function automatic logic [63:0] pow10(input int e);
        logic [63:0] r;
        r = 64'd1;
        for (int i = 0; i < 19; i++) begin
            if (i < e) r = r * 64'd10;
        end
        return r;
    endfunction

    // Fixed command head, one character per index.
    function automatic logic [7:0] head_char(input logic [1:0] k);
        case (k)
            2'd0:    return CH_COLON;
            2'd1:    return CH_S;
            2'd2:    return CH_ONE;
            default: return CH_F;
        endcase
    endfunction

endpackage

// File: rtl/sweep_uart_tx.sv
module sweep_uart_tx
    import sweep_pkg::*;
#(
    parameter int BIT_CLKS = 1736
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] data,
    output logic       ready,
    output logic       line
);
    localparam int CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BIT_CLKS - 1);

    line_state_t   st;
    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    shreg;

    assign ready = (st == LN_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= LN_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
            line  <= 1'b1;
        end else begin
            case (st)
                LN_IDLE: begin
                    line <= 1'b1;
                    if (load) begin
                        shreg <= data;
                        cnt   <= '0;
                        line  <= 1'b0;
                        st    <= LN_START;
                    end
                end
                LN_START: begin
                    if (cnt == LAST) begin
                        cnt  <= '0;
                        bitn <= '0;
                        line <= shreg[0];
                        st   <= LN_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                LN_DATA: begin
                    if (cnt == LAST) begin
                        cnt <= '0;
                        if (bitn == 3'd7) begin
                            line <= 1'b1;
                            st   <= LN_STOP;
                        end else begin
                            bitn  <= bitn + 1'b1;
                            shreg <= {1'b0, shreg[7:1]};
                            line  <= shreg[1];
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == LAST) begin
                        cnt <= '0;
                        st  <= LN_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/sweep_dec_conv.sv
module sweep_dec_conv
    import sweep_pkg::*;
#(
    parameter  int VAL_W = 32,
    parameter  int NDIG  = 9,
    localparam int POS_W = (NDIG > 1) ? $clog2(NDIG) : 1,
    localparam int CNT_W = $clog2(NDIG + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  logic [VAL_W-1:0]      value,
    output logic                  ready,
    output logic [NDIG-1:0][3:0]  digits,
    output logic [CNT_W-1:0]      width
);
    logic [VAL_W-1:0] rem;
    logic [POS_W-1:0] pos;
    logic             running;
    logic [63:0]      weight;
    logic             take;

    assign weight = pow10(int'(pos));
    assign take   = ({{(64-VAL_W){1'b0}}, rem} >= weight);

    // Repeated subtraction, one decimal weight per cycle, top digit first.
    always_ff @(posedge clk) begin
        if (rst) begin
            rem     <= '0;
            pos     <= '0;
            running <= 1'b0;
            ready   <= 1'b0;
            digits  <= '0;
        end else if (go) begin
            rem     <= value;
            pos     <= POS_W'(NDIG - 1);
            digits  <= '0;
            running <= 1'b1;
            ready   <= 1'b0;
        end else if (running) begin
            if (take) begin
                rem         <= rem - weight[VAL_W-1:0];
                digits[pos] <= digits[pos] + 4'd1;
            end else if (pos == '0) begin
                running <= 1'b0;
                ready   <= 1'b1;
            end else begin
                pos <= pos - 1'b1;
            end
        end
    end

    // Count of significant digits; zero still yields one digit.
    always_comb begin
        width = CNT_W'(1);
        for (int i = 1; i < NDIG; i++) begin
            if (digits[i] != 4'd0) width = CNT_W'(i + 1);
        end
    end

endmodule

// File: rtl/sweep_cmd_gen.sv
module sweep_cmd_gen
    import sweep_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int BAUD   = 57_600,
    parameter int FREQ_W = 32,
    parameter int NDIG   = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FREQ_W-1:0] start_freq,
    input  logic [FREQ_W-1:0] stop_freq,
    input  logic [FREQ_W-1:0] step_freq,
    input  logic              handshake_en,
    input  logic              point_done,
    output logic              busy,
    output logic              done,
    output logic              point_sent,
    output logic              tx
);
    localparam int BIT_CLKS = CLK_HZ / BAUD;
    localparam int IDX_W    = (NDIG > 4) ? $clog2(NDIG) : 2;
    localparam int CNT_W    = $clog2(NDIG + 1);

    seq_state_t          state;
    fld_t                fld;
    logic [IDX_W-1:0]    idx;
    logic [FREQ_W-1:0]   cur;
    logic [FREQ_W-1:0]   stop_r;
    logic [FREQ_W-1:0]   step_r;
    logic                conv_go;
    logic                conv_ready;
    logic [NDIG-1:0][3:0] digs;
    logic [CNT_W-1:0]    nsig;
    logic [7:0]          tx_byte;
    logic                byte_ok;
    logic                tx_ready;
    logic                tx_load;
    logic [FREQ_W:0]     nxt;
    logic                more;
    logic                advance;

    sweep_dec_conv #(
        .VAL_W (FREQ_W),
        .NDIG  (NDIG)
    ) u_conv (
        .clk    (clk),
        .rst    (rst),
        .go     (conv_go),
        .value  (cur),
        .ready  (conv_ready),
        .digits (digs),
        .width  (nsig)
    );

    sweep_uart_tx #(
        .BIT_CLKS (BIT_CLKS)
    ) u_tx (
        .clk   (clk),
        .rst   (rst),
        .load  (tx_load),
        .data  (tx_byte),
        .ready (tx_ready),
        .line  (tx)
    );

    assign nxt     = {1'b0, cur} + {1'b0, step_r};
    assign more    = (nxt < {1'b0, stop_r});
    assign advance = ((state == SQ_DRAIN) && tx_ready && !handshake_en)
                   || ((state == SQ_HOLD) && point_done);
    assign busy    = (state != SQ_IDLE);

    // Byte selection for the current field of the command.
    always_comb begin
        tx_byte = '0;
        byte_ok = 1'b0;
        if (state == SQ_EMIT) begin
            case (fld)
                FLD_HEAD: begin
                    tx_byte = head_char(idx[1:0]);
                    byte_ok = 1'b1;
                end
                FLD_DIGIT: begin
                    tx_byte = CH_ZERO + {4'b0000, digs[idx]};
                    byte_ok = 1'b1;
                end
                FLD_CR: begin
                    tx_byte = CH_CR;
                    byte_ok = 1'b1;
                end
                FLD_LF: begin
                    tx_byte = CH_LF;
                    byte_ok = 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign tx_load = byte_ok && tx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_IDLE;
            fld        <= FLD_HEAD;
            idx        <= '0;
            cur        <= '0;
            stop_r     <= '0;
            step_r     <= '0;
            conv_go    <= 1'b0;
            done       <= 1'b0;
            point_sent <= 1'b0;
        end else begin
            conv_go    <= 1'b0;
            done       <= 1'b0;
            point_sent <= 1'b0;
            case (state)
                SQ_IDLE: if (start) begin
                    cur    <= start_freq;
                    stop_r <= stop_freq;
                    step_r <= step_freq;
                    if (start_freq < stop_freq) begin
                        conv_go <= 1'b1;
                        fld     <= FLD_HEAD;
                        idx     <= '0;
                        state   <= SQ_EMIT;
                    end else begin
                        done <= 1'b1;
                    end
                end
                SQ_EMIT: begin
                    if (tx_load) begin
                        case (fld)
                            FLD_HEAD:
                                if (idx == IDX_W'(3)) fld <= FLD_SIZE;
                                else idx <= idx + 1'b1;
                            FLD_DIGIT:
                                if (idx == '0) fld <= FLD_CR;
                                else idx <= idx - 1'b1;
                            FLD_CR: fld <= FLD_LF;
                            FLD_LF: state <= SQ_DRAIN;
                            default: ;
                        endcase
                    end else if ((fld == FLD_SIZE) && conv_ready) begin
                        fld <= FLD_DIGIT;
                        idx <= IDX_W'(nsig - CNT_W'(1));
                    end
                end
                SQ_DRAIN: if (tx_ready) begin
                    point_sent <= 1'b1;
                    if (handshake_en) state <= SQ_HOLD;
                end
                default: ;
            endcase
            if (advance) begin
                if (more) begin
                    cur     <= nxt[FREQ_W-1:0];
                    conv_go <= 1'b1;
                    fld     <= FLD_HEAD;
                    idx     <= '0;
                    state   <= SQ_EMIT;
                end else begin
                    done  <= 1'b1;
                    state <= SQ_IDLE;
                end
            end
        end
    end

endmodule

// File: rtl/sweep_cmd_gen_chk.sv
module sweep_cmd_gen_chk (
    input logic clk,
    input logic rst,
    input logic handshake_en,
    input logic point_done,
    input logic busy,
    input logic done,
    input logic point_sent,
    input logic tx
);
    logic waiting;

    always_ff @(posedge clk) begin
        if (rst) waiting <= 1'b0;
        else if (point_done) waiting <= 1'b0;
        else if (point_sent && handshake_en) waiting <= 1'b1;
    end

    p_idle_high_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx);

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_sent_single_r10: assert property (@(posedge clk) disable iff (rst)
        point_sent |=> !point_sent);

    p_hold_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        waiting |-> (tx && busy));

endmodule

bind sweep_cmd_gen sweep_cmd_gen_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .handshake_en (handshake_en),
    .point_done   (point_done),
    .busy         (busy),
    .done         (done),
    .point_sent   (point_sent),
    .tx           (tx)
);

// File: tb/sweep_cmd_gen_test.sv
module sweep_cmd_gen_test;
    localparam int BITC = 8;
    localparam int BAUD = 57_600;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] start_freq = '0;
    logic [31:0] stop_freq = '0;
    logic [31:0] step_freq = '0;
    logic        handshake_en = 1'b0;
    logic        point_done = 1'b0;
    logic        busy, done, point_sent, tx;

    always #2.5 clk = ~clk;

    sweep_cmd_gen #(
        .CLK_HZ (BITC * BAUD),
        .BAUD   (BAUD)
    ) uut (
        .clk (clk), .rst (rst), .start (start),
        .start_freq (start_freq), .stop_freq (stop_freq), .step_freq (step_freq),
        .handshake_en (handshake_en), .point_done (point_done),
        .busy (busy), .done (done), .point_sent (point_sent), .tx (tx)
    );

    int checks = 0;
    int errors = 0;
    byte unsigned rxq[$];
    bit rx_mute = 1'b0;
    bit gap_on = 1'b0;
    bit have_prev = 1'b0;
    int idle_ctr = 0;
    int gap_max = 0;
    int done_cnt = 0;
    int done_bad = 0;
    int sent_cnt = 0;
    bit prev_done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Line receiver: checks R3 framing and timing at bit centres.
    initial begin
        forever begin
            @(negedge clk);
            if (tx === 1'b0 && !rst) begin
                byte unsigned b;
                bit okf;
                if (gap_on && have_prev && idle_ctr > gap_max) gap_max = idle_ctr;
                repeat (BITC / 2) @(negedge clk);
                okf = (tx == 1'b0);
                for (int k = 0; k < 8; k++) begin
                    repeat (BITC) @(negedge clk);
                    b[k] = tx;
                end
                repeat (BITC) @(negedge clk);
                okf = okf && (tx == 1'b1);
                if (!rx_mute) begin
                    chk(okf, "R3", "start/stop bit level", longint'(okf), 1);
                    rxq.push_back(b);
                end
                idle_ctr = 0;
                have_prev = 1'b1;
            end else begin
                idle_ctr++;
            end
        end
    end

    // Pulse monitor for done and point_sent.
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                done_cnt++;
                if (busy || prev_done) done_bad++;
            end
            if (point_sent) sent_cnt++;
        end
        prev_done = done;
    end

    task automatic expect_frame(input longint f, input string req);
        string e;
        int lim;
        bit ok;
        e = $sformatf(":s1f%0d\r\n", f);
        lim = 0;
        while (rxq.size() < e.len() && lim < 5000) begin
            @(negedge clk);
            lim++;
        end
        ok = (rxq.size() >= e.len());
        if (!ok) begin
            chk(0, req, "frame bytes received", rxq.size(), e.len());
            return;
        end
        for (int i = 0; i < e.len(); i++) begin
            byte unsigned b;
            b = rxq.pop_front();
            if (ok && b != e[i]) begin
                ok = 0;
                chk(0, req, $sformatf("byte %0d of frame for %0d", i, f), b, e[i]);
            end
        end
        if (ok) chk(1, req, "frame", f, f);
    endtask

    task automatic wait_sent(input int target);
        int lim;
        lim = 0;
        while (sent_cnt < target && lim < 4 * BITC) begin
            @(negedge clk);
            lim++;
        end
        chk(sent_cnt == target, "R10", "point_sent pulses", sent_cnt, target);
    endtask

    task automatic run_sweep(input longint s, input longint e, input longint st,
                             input bit hs, input bit poke, input string req);
        longint f;
        int npt;
        int d0;
        int s0;
        d0 = done_cnt;
        s0 = sent_cnt;
        gap_on = !hs;
        have_prev = 1'b0;
        gap_max = 0;
        @(negedge clk);
        start_freq = 32'(s);
        stop_freq = 32'(e);
        step_freq = 32'(st);
        handshake_en = hs;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R7", "busy after start", busy, 1);
        f = s;
        npt = 0;
        while (f < e) begin
            expect_frame(f, req);
            npt++;
            wait_sent(s0 + npt);
            if (poke && npt == 1) begin
                // R8: late start with different values must be ignored
                start_freq = 32'd7;
                stop_freq = 32'd100;
                step_freq = 32'd1;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            if (hs) begin
                bit quiet;
                quiet = 1'b1;
                repeat (60) begin
                    @(negedge clk);
                    if (tx != 1'b1 || busy != 1'b1 || done_cnt != d0) quiet = 1'b0;
                end
                chk(quiet && rxq.size() == 0, "R6", "line idle during hold", quiet, 1);
                point_done = 1'b1;
                @(negedge clk);
                point_done = 1'b0;
            end
            f = f + st;
        end
        begin
            int lim;
            lim = 0;
            while (done_cnt == d0 && lim < 4 * BITC) begin
                @(negedge clk);
                lim++;
            end
        end
        chk(done_cnt == d0 + 1, "R7", "done pulses at sweep end", done_cnt - d0, 1);
        chk(done_bad == 0, "R7", "done width/busy overlap faults", done_bad, 0);
        repeat (3 * BITC * 10) @(negedge clk);
        chk(rxq.size() == 0 && !busy, "R4", "no bytes after last point", rxq.size(), 0);
        if (!hs && npt > 1) chk(gap_max <= BITC / 2 + 2, "R5", "max idle gap", gap_max, BITC / 2 + 2);
        gap_on = 1'b0;
    endtask

    initial begin
        repeat (190_000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(tx == 1'b1 && busy == 1'b0 && done == 1'b0, "R9", "reset state", {tx, busy, done}, 3'b100);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        chk(tx == 1'b1, "R3", "idle line high", tx, 1);

        // Tail of the default sweep: last point below the limit.
        run_sweep(89_997_000, 90_000_000, 1000, 1'b0, 1'b0, "R4");
        // Nine-digit values.
        run_sweep(999_999_990, 999_999_999, 5, 1'b0, 1'b0, "R2");
        // Zero and short values, leading zeros suppressed.
        run_sweep(0, 30, 7, 1'b0, 1'b0, "R2");
        // Frame layout with handshake pacing.
        run_sweep(1_000_000, 1_002_500, 1000, 1'b1, 1'b0, "R1");
        // Late start request ignored.
        run_sweep(5000, 5300, 100, 1'b0, 1'b1, "R8");

        // Empty sweep: no bytes, single done.
        begin
            int d0;
            d0 = done_cnt;
            @(negedge clk);
            start_freq = 32'd500;
            stop_freq = 32'd500;
            step_freq = 32'd10;
            handshake_en = 1'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            chk(done_cnt == d0 + 1 && !busy, "R4", "empty sweep done", done_cnt - d0, 1);
            repeat (200) @(negedge clk);
            chk(rxq.size() == 0, "R4", "empty sweep bytes", rxq.size(), 0);
        end

        // Random sweeps.
        for (int r = 0; r < 8; r++) begin
            longint s, st, e;
            int n;
            if (r < 3) s = $urandom_range(0, 99);
            else s = $urandom_range(0, 990_000_000);
            st = $urandom_range(1, 200_000);
            n = $urandom_range(1, 3);
            e = s + st * (n - 1) + 1 + ($urandom % st);
            run_sweep(s, e, st, r[0], 1'b0, "R2");
        end

        // Reset in the middle of a sweep.
        begin
            bit quiet;
            @(negedge clk);
            start_freq = 32'd123_456;
            stop_freq = 32'd200_000;
            step_freq = 32'd1;
            handshake_en = 1'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (300) @(negedge clk);
            rx_mute = 1'b1;
            rst = 1'b1;
            @(negedge clk);
            chk(tx == 1'b1 && busy == 1'b0 && done == 1'b0, "R9", "mid-sweep reset", {tx, busy, done}, 3'b100);
            rst = 1'b0;
            quiet = 1'b1;
            repeat (150) begin
                @(negedge clk);
                if (tx != 1'b1 || busy) quiet = 1'b0;
            end
            chk(quiet, "R9", "idle after reset", quiet, 1);
            rxq.delete();
            rx_mute = 1'b0;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule